// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block keeps the per-line state of a small interrupt controller behind a 32-bit register bus. For each line it stores an enable bit, a pending bit, a priority byte, a target byte and a 2-bit trigger configuration. A single global enable gates every line. Software changes enable and pending state through separate set and clear aliases, so it never needs a read-modify-write. Priority and target bytes can each be written on their own through the byte lanes.

The raw interrupt inputs are sampled every cycle. A line configured for edge triggering latches pending on a low-to-high transition. A line configured for level triggering reads as pending while its sampled input is high. The block exports, for each line, whether it is globally enabled, enabled and pending. It also exports the priority and target bytes, for an arbiter placed downstream. Selecting a winner and the processor handshake belong to other blocks.

The line count `NUM_LINES` is a multiple of 32. Register reads are combinational from the word address. Writes take effect at the clock edge on which `bus_wr` is high.

Top module: `intdist_regbank`

## Requirements
- R1: After a synchronous active-low reset, every enable, pending, priority, target, configuration and global-enable bit is 0, and `line_fwd` is all 0.
- R2: Bit 0 of the control word (byte address 0x000) is the global enable. `line_fwd[l]` is 1 exactly when the global enable is 1, line l is enabled and line l is pending. Writing the control word with bit 0 clear forces `line_fwd` to all 0 from the next cycle.
- R3: The type word (0x004) reads `NUM_LINES/32 - 1` in bits 4:0 and 0 elsewhere. Writes to it have no effect.
- R4: Enable state for line l sits in bit l%32 of word 0x100 + 4*(l/32) (set alias) and of word 0x180 + 4*(l/32) (clear alias). Writing a 1 sets or clears the bit, and writing a 0 leaves it unchanged. Only enabled byte lanes (`bus_be[k]` covers bits 8k+7:8k) take effect. Both aliases read the current state.
- R5: Pending state uses the same layout and rules as R4, at set base 0x200 and clear base 0x280.
- R6: The priority byte of line l is at byte address 0x400 + l and the target byte at 0x800 + l. A word read returns line 4w+k in bits 8k+7:8k. A write changes only the bytes whose lane is enabled. Line l's bytes appear on `line_prio[8l+7:8l]` and `line_tgt[8l+7:8l]`.
- R7: The 2-bit configuration field of line l is at word 0xC00 + 4*(l/16), bits 2*(l%16)+1:2*(l%16). Both bits are stored and read back. Field bit 1 set selects edge triggering, and clear selects level triggering.
- R8: On an edge-configured line, a 0-to-1 change of `irq_in[l]` between two consecutive clock edges sets pending at the second edge. Pending stays set after the input falls, until a pending-clear write. A clear while the input stays high leaves the bit clear.
- R9: On a level-configured line, pending reads 1 from the edge after the input is seen high and 0 from the edge after it is seen low. A pending-set write latches a software pending that holds until cleared.
- R10: Words or bytes that fall beyond `NUM_LINES`, the active-set and active-clear words (0x300, 0x380) and all unmapped addresses ignore writes and read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 10 | Word address (byte address bits 11:2) |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_be | input | 4 | Byte-lane enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word, combinational |
| irq_in | input | NUM_LINES | Raw interrupt inputs |
| line_fwd | output | NUM_LINES | Per line: global enable, line enable and pending all set |
| line_prio | output | 8*NUM_LINES | Priority byte per line |
| line_tgt | output | 8*NUM_LINES | Target byte per line |

## Verification
The assertions assume that `irq_in` is synchronous to `clk`. They also assume that a write touches one region only, so a set alias and its clear alias are never written in the same cycle. The bench changes inputs only on the falling edge, issues one write per cycle and holds each interrupt pulse for at least one full cycle. This keeps every edge visible to the sampling register. The sweeps cover every implemented word and byte, and in addition the first word past the last line.

// File: rtl/intdist_pkg.sv
// Shared types for the interrupt distributor register bank.
// Assumes a 32-bit data bus with four byte lanes.
package intdist_pkg;

    // Address regions decoded from the word address.
    typedef enum logic [3:0] {
        RG_NONE,
        RG_CTRL,
        RG_TYPE,
        RG_EN_SET,
        RG_EN_CLR,
        RG_PD_SET,
        RG_PD_CLR,
        RG_ACT,
        RG_PRIO,
        RG_TGT,
        RG_CFG
    } region_e;

    // Expand four byte enables into a 32-bit bit mask.
    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

endpackage

// File: rtl/intdist_decode.sv
// Address decoder: maps a word address onto a register region and a
// word index inside that region. Purely combinational.
// Assumes the region map fits a 4 KiB window.
module intdist_decode
    import intdist_pkg::*;
(
    input  logic [11:2] addr,
    output region_e     region,
    output logic [7:0]  idx
);

    // Classify the address and extract the index within the region.
    always_comb begin
        region = RG_NONE;
        idx    = {3'b000, addr[6:2]};
        if (addr[11:2] == 10'd0) begin
            region = RG_CTRL;
        end else if (addr[11:2] == 10'd1) begin
            region = RG_TYPE;
        end else if (addr[11:10] == 2'b01) begin
            region = RG_PRIO;
            idx    = addr[9:2];
        end else if (addr[11:10] == 2'b10) begin
            region = RG_TGT;
            idx    = addr[9:2];
        end else if (addr[11:8] == 4'hC) begin
            region = RG_CFG;
            idx    = {2'b00, addr[7:2]};
        end else begin
            case (addr[11:7])
                5'h02:   region = RG_EN_SET;
                5'h03:   region = RG_EN_CLR;
                5'h04:   region = RG_PD_SET;
                5'h05:   region = RG_PD_CLR;
                5'h06,
                5'h07:   region = RG_ACT;
                default: region = RG_NONE;
            endcase
        end
    end

endmodule

// File: rtl/intdist_byte_array.sv
// One byte per line, written through byte lanes and read as 32-bit words.
// Line 4w+k lives in lane k of word w. Used for priority and target.
// Assumes NUM_LINES <= 1024 (8-bit word index).
module intdist_byte_array #(
    parameter int NUM_LINES = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr,
    input  logic [7:0]             idx,
    input  logic [3:0]             be,
    input  logic [31:0]            wdata,
    output logic [8*NUM_LINES-1:0] bytes_flat,
    output logic [31:0]            rd_word
);

    genvar l;
    generate
        for (l = 0; l < NUM_LINES; l++) begin : g_byte
            localparam int WI   = l / 4;
            localparam int LANE = l % 4;
            // Store this line's byte when its word and lane are written.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bytes_flat[8*l +: 8] <= 8'h00;
                end else if (wr && idx == 8'(WI) && be[LANE]) begin
                    bytes_flat[8*l +: 8] <= wdata[8*LANE +: 8];
                end
            end
        end
    endgenerate

    // Gather the four bytes of the addressed word; absent lines read 0.
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (idx == 8'(i / 4)) begin
                rd_word[8*(i%4) +: 8] = bytes_flat[8*i +: 8];
            end
        end
    end

    // Without a write strobe the byte storage must not move.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(bytes_flat));

endmodule

// File: rtl/intdist_line_state.sv
// Per-line enable, pending and trigger configuration.
// Samples irq_in once per cycle; edge lines latch on a rising sample,
// level lines follow the sampled input plus a software latch.
// Assumes irq_in is synchronous to clk and that the set and clear masks
// for the same state are never both non-zero in one cycle.
module intdist_line_state #(
    parameter int NUM_LINES = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_LINES-1:0]   en_set_m,
    input  logic [NUM_LINES-1:0]   en_clr_m,
    input  logic [NUM_LINES-1:0]   pd_set_m,
    input  logic [NUM_LINES-1:0]   pd_clr_m,
    input  logic                   cfg_we,
    input  logic [7:0]             cfg_idx,
    input  logic [3:0]             be,
    input  logic [31:0]            wdata,
    input  logic [NUM_LINES-1:0]   irq_in,
    output logic [NUM_LINES-1:0]   en_q,
    output logic [NUM_LINES-1:0]   pend,
    output logic [2*NUM_LINES-1:0] cfg_q
);

    genvar l;
    generate
        for (l = 0; l < NUM_LINES; l++) begin : g_line
            localparam int CW   = l / 16;
            localparam int SH   = 2 * (l % 16);
            localparam int LANE = (l % 16) / 4;

            logic irq_s;
            logic pend_q;
            logic edge_mode;

            assign edge_mode = cfg_q[2*l+1];

            // Register the raw input for edge detection and level tracking.
            always_ff @(posedge clk) begin
                if (!rst_n) irq_s <= 1'b0;
                else        irq_s <= irq_in[l];
            end

            // Enable bit: set alias and clear alias.
            always_ff @(posedge clk) begin
                if (!rst_n)           en_q[l] <= 1'b0;
                else if (en_set_m[l]) en_q[l] <= 1'b1;
                else if (en_clr_m[l]) en_q[l] <= 1'b0;
            end

            // Configuration field, written through its byte lane.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cfg_q[2*l +: 2] <= 2'b00;
                end else if (cfg_we && cfg_idx == 8'(CW) && be[LANE]) begin
                    cfg_q[2*l +: 2] <= wdata[SH +: 2];
                end
            end

            // Pending latch: software set, rising edge on edge lines, software clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend_q <= 1'b0;
                end else begin
                    pend_q <= (pend_q & ~pd_clr_m[l]) | pd_set_m[l]
                            | (edge_mode & irq_in[l] & ~irq_s);
                end
            end

            assign pend[l] = pend_q | (~edge_mode & irq_s);

            p_edge_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (edge_mode && irq_in[l] && !irq_s && !pd_clr_m[l]) |=> pend[l]);

            p_level_track_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (!edge_mode && irq_in[l]) |=> (edge_mode || pend[l]));

            p_en_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
                en_set_m[l] |=> en_q[l]);

            p_en_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (en_clr_m[l] && !en_set_m[l]) |=> !en_q[l]);

            p_pd_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
                pd_set_m[l] |=> pend[l]);
        end
    endgenerate

endmodule

// File: rtl/intdist_regbank.sv
// Interrupt distributor register bank (top).
// Holds per-line enable, pending, priority, target and trigger
// configuration behind a 32-bit byte-lane register bus, and exports
// per-line forward status and bytes for a downstream arbiter.
// Assumes NUM_LINES is a multiple of 32 and at most 1024.
module intdist_regbank
    import intdist_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [11:2]            bus_addr,
    input  logic                   bus_wr,
    input  logic [3:0]             bus_be,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic [NUM_LINES-1:0]   irq_in,
    output logic [NUM_LINES-1:0]   line_fwd,
    output logic [8*NUM_LINES-1:0] line_prio,
    output logic [8*NUM_LINES-1:0] line_tgt
);

    localparam int WORDS     = NUM_LINES / 32;
    localparam int CFG_WORDS = NUM_LINES / 16;
    localparam int TYPE_VAL  = WORDS - 1;

    region_e                 region;
    logic [7:0]              idx;
    logic [31:0]             wmask;
    logic                    glb_en;
    logic [NUM_LINES-1:0]    en_set_m, en_clr_m, pd_set_m, pd_clr_m;
    logic [NUM_LINES-1:0]    en_q, pend;
    logic [2*NUM_LINES-1:0]  cfg_q;
    logic [31:0]             prio_rd, tgt_rd;

    intdist_decode u_dec (
        .addr   (bus_addr),
        .region (region),
        .idx    (idx)
    );

    assign wmask = lane_mask(bus_be) & bus_wdata;

    // Build per-line set/clear masks for each implemented bitmap word.
    genvar w;
    generate
        for (w = 0; w < WORDS; w++) begin : g_word
            logic hit;
            assign hit = bus_wr && idx == 8'(w);
            assign en_set_m[32*w +: 32] = (hit && region == RG_EN_SET) ? wmask : 32'h0;
            assign en_clr_m[32*w +: 32] = (hit && region == RG_EN_CLR) ? wmask : 32'h0;
            assign pd_set_m[32*w +: 32] = (hit && region == RG_PD_SET) ? wmask : 32'h0;
            assign pd_clr_m[32*w +: 32] = (hit && region == RG_PD_CLR) ? wmask : 32'h0;
        end
    endgenerate

    // Global enable in bit 0 of the control word.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   glb_en <= 1'b0;
        else if (bus_wr && region == RG_CTRL && bus_be[0]) glb_en <= bus_wdata[0];
    end

    intdist_line_state #(.NUM_LINES(NUM_LINES)) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_set_m (en_set_m),
        .en_clr_m (en_clr_m),
        .pd_set_m (pd_set_m),
        .pd_clr_m (pd_clr_m),
        .cfg_we   (bus_wr && region == RG_CFG),
        .cfg_idx  (idx),
        .be       (bus_be),
        .wdata    (bus_wdata),
        .irq_in   (irq_in),
        .en_q     (en_q),
        .pend     (pend),
        .cfg_q    (cfg_q)
    );

    intdist_byte_array #(.NUM_LINES(NUM_LINES)) u_prio (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (bus_wr && region == RG_PRIO),
        .idx        (idx),
        .be         (bus_be),
        .wdata      (bus_wdata),
        .bytes_flat (line_prio),
        .rd_word    (prio_rd)
    );

    intdist_byte_array #(.NUM_LINES(NUM_LINES)) u_tgt (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (bus_wr && region == RG_TGT),
        .idx        (idx),
        .be         (bus_be),
        .wdata      (bus_wdata),
        .bytes_flat (line_tgt),
        .rd_word    (tgt_rd)
    );

    assign line_fwd = {NUM_LINES{glb_en}} & en_q & pend;

    // Read multiplexer; anything unimplemented returns 0.
    always_comb begin
        bus_rdata = '0;
        case (region)
            RG_CTRL: bus_rdata = {31'b0, glb_en};
            RG_TYPE: bus_rdata = 32'(TYPE_VAL);
            RG_EN_SET, RG_EN_CLR: begin
                for (int i = 0; i < WORDS; i++)
                    if (idx == 8'(i)) bus_rdata = en_q[32*i +: 32];
            end
            RG_PD_SET, RG_PD_CLR: begin
                for (int i = 0; i < WORDS; i++)
                    if (idx == 8'(i)) bus_rdata = pend[32*i +: 32];
            end
            RG_PRIO: bus_rdata = prio_rd;
            RG_TGT:  bus_rdata = tgt_rd;
            RG_CFG: begin
                for (int i = 0; i < CFG_WORDS; i++)
                    if (idx == 8'(i)) bus_rdata = cfg_q[32*i +: 32];
            end
            default: bus_rdata = '0;
        endcase
    end

    p_gate_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && region == RG_CTRL && bus_be[0] && !bus_wdata[0]) |=> (line_fwd == '0));

endmodule

// File: tb/tb_intdist_regbank.sv
module tb_intdist_regbank;

    localparam int N = 96;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [11:2]    bus_addr = '0;
    logic           bus_wr = 1'b0;
    logic [3:0]     bus_be = 4'h0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [N-1:0]   irq_in = '0;
    logic [N-1:0]   line_fwd;
    logic [8*N-1:0] line_prio;
    logic [8*N-1:0] line_tgt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    intdist_regbank #(.NUM_LINES(N)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .line_fwd(line_fwd), .line_prio(line_prio),
        .line_tgt(line_tgt)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a[11:2]; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 4'h0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a[11:2];
        #1 d = bus_rdata;
    endtask

    function automatic logic [7:0] pval(input int l);
        return 8'((l * 7 + 3) & 8'hFF);
    endfunction

    function automatic logic [7:0] tval(input int l);
        return 8'(l) ^ 8'h5A;
    endfunction

    initial begin
        logic [31:0] d;
        logic [31:0] pat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(12'h000, d); check("R1 ctrl", d, 0);
        for (int w = 0; w < N/32; w++) begin
            rd(12'(12'h100 + 4*w), d); check("R1 enable", d, 0);
            rd(12'(12'h200 + 4*w), d); check("R1 pending", d, 0);
        end
        rd(12'h400, d); check("R1 prio", d, 0);
        rd(12'hC00, d); check("R1 cfg", d, 0);
        check("R1 fwd", 32'(line_fwd[31:0]), 0);

        // R3 type word, write ignored
        rd(12'h004, d); check("R3 type", d, N/32 - 1);
        wr(12'h004, 4'hF, 32'hFFFF_FFFF);
        rd(12'h004, d); check("R3 type after write", d, N/32 - 1);

        // R4 / R5 set-clear sweeps over every implemented word
        for (int w = 0; w < N/32; w++) begin
            pat = 32'hA5C3_5A3C ^ (32'h1111_1111 * 32'(w));
            wr(12'(12'h100 + 4*w), 4'hF, pat);
            rd(12'(12'h100 + 4*w), d); check("R4 set", d, pat);
            wr(12'(12'h180 + 4*w), 4'hF, 32'h0F0F_0F0F);
            rd(12'(12'h180 + 4*w), d); check("R4 clear alias read", d, pat & ~32'h0F0F_0F0F);
            wr(12'(12'h100 + 4*w), 4'hF, 32'h0);
            rd(12'(12'h100 + 4*w), d); check("R4 zero write no change", d, pat & ~32'h0F0F_0F0F);
            wr(12'(12'h180 + 4*w), 4'hF, 32'hFFFF_FFFF);

            wr(12'(12'h200 + 4*w), 4'hF, ~pat);
            rd(12'(12'h280 + 4*w), d); check("R5 set", d, ~pat);
            wr(12'(12'h280 + 4*w), 4'hF, 32'hFFFF_0000);
            rd(12'(12'h200 + 4*w), d); check("R5 clear", d, ~pat & 32'h0000_FFFF);
            wr(12'(12'h280 + 4*w), 4'hF, 32'hFFFF_FFFF);
            rd(12'(12'h200 + 4*w), d); check("R5 all clear", d, 0);
        end
        // R4 byte lanes and the low-16 enable pattern
        wr(12'h100, 4'b0010, 32'hFFFF_FFFF);
        rd(12'h100, d); check("R4 byte lane", d, 32'h0000_FF00);
        wr(12'h100, 4'hF, 32'h0000_FFFF);
        rd(12'h100, d); check("R4 low sixteen", d, 32'h0000_FFFF);
        wr(12'h180, 4'hF, 32'hFFFF_FFFF);

        // R10 beyond-range bitmap words, active words, unmapped
        wr(12'(12'h100 + 4*(N/32)), 4'hF, 32'hFFFF_FFFF);
        rd(12'(12'h100 + 4*(N/32)), d); check("R10 enable beyond", d, 0);
        wr(12'h300, 4'hF, 32'hFFFF_FFFF);
        rd(12'h300, d); check("R10 active set", d, 0);
        rd(12'h380, d); check("R10 active clear", d, 0);
        rd(12'hE00, d); check("R10 unmapped", d, 0);
        for (int w = 0; w < N/32; w++) begin
            rd(12'(12'h100 + 4*w), d); check("R10 enable untouched", d, 0);
        end

        // R6 priority: one byte per write, all lines
        for (int l = 0; l < N; l++)
            wr(12'(12'h400 + l), 4'(1 << (l % 4)), 32'(pval(l)) << (8 * (l % 4)));
        for (int w = 0; w < N/4; w++) begin
            rd(12'(12'h400 + 4*w), d);
            check("R6 prio word", d, {pval(4*w+3), pval(4*w+2), pval(4*w+1), pval(4*w)});
        end
        for (int l = 0; l < N; l++)
            check("R6 prio export", 32'(line_prio[8*l +: 8]), 32'(pval(l)));
        // R6 target: full-word writes
        for (int w = 0; w < N/4; w++)
            wr(12'(12'h800 + 4*w), 4'hF, {tval(4*w+3), tval(4*w+2), tval(4*w+1), tval(4*w)});
        for (int l = 0; l < N; l++)
            check("R6 target export", 32'(line_tgt[8*l +: 8]), 32'(tval(l)));
        wr(12'h804, 4'b0100, 32'h00EE_0000);
        rd(12'h804, d); check("R6 target lane", d, {tval(7), 8'hEE, tval(5), tval(4)});
        // R10 bytes beyond the last line
        wr(12'(12'h400 + N), 4'hF, 32'hFFFF_FFFF);
        rd(12'(12'h400 + N), d); check("R10 prio beyond", d, 0);
        rd(12'(12'h400 + N - 4), d);
        check("R10 prio last intact", d, {pval(N-1), pval(N-2), pval(N-3), pval(N-4)});

        // R7 configuration words
        for (int w = 0; w < N/16; w++) begin
            pat = 32'h6C93_1E47 + 32'(w);
            wr(12'(12'hC00 + 4*w), 4'hF, pat);
            rd(12'(12'hC00 + 4*w), d); check("R7 cfg readback", d, pat);
        end
        wr(12'(12'hC00 + 4*(N/16)), 4'hF, 32'hFFFF_FFFF);
        rd(12'(12'hC00 + 4*(N/16)), d); check("R10 cfg beyond", d, 0);
        // line 3 edge (field bits 7:6 = 2'b10), line 20 level (word 1 zero)
        for (int w = 0; w < N/16; w++) wr(12'(12'hC00 + 4*w), 4'hF, 32'h0);
        wr(12'hC00, 4'h1, 32'h0000_0080);
        rd(12'hC00, d); check("R7 edge field", d, 32'h0000_0080);

        // R8 edge latching
        @(negedge clk); irq_in[3] = 1'b1;
        @(negedge clk); irq_in[3] = 1'b0;
        rd(12'h200, d); check("R8 edge latched", d, 32'h0000_0008);
        rd(12'h200, d); check("R8 held after fall", d, 32'h0000_0008);
        @(negedge clk); irq_in[3] = 1'b1;
        wr(12'h280, 4'hF, 32'h0000_0008);
        rd(12'h200, d); check("R8 clear with input high", d, 0);
        @(negedge clk); irq_in[3] = 1'b0;

        // R9 level following and software latch
        @(negedge clk); irq_in[20] = 1'b1;
        rd(12'h200, d); check("R9 level high", d, 32'h0010_0000);
        @(negedge clk); irq_in[20] = 1'b0;
        rd(12'h200, d); check("R9 level low", d, 0);
        wr(12'h200, 4'hF, 32'h0010_0000);
        rd(12'h200, d); check("R9 software latch", d, 32'h0010_0000);
        wr(12'h280, 4'hF, 32'h0010_0000);
        rd(12'h200, d); check("R9 latch cleared", d, 0);

        // R2 forwarding and global gate
        wr(12'h100, 4'hF, 32'h0000_0008);
        wr(12'h200, 4'hF, 32'h0000_0018);
        @(negedge clk); check("R2 gate off", 32'(line_fwd[31:0]), 0);
        wr(12'h000, 4'h1, 32'h1);
        rd(12'h000, d); check("R2 ctrl read", d, 1);
        check("R2 forward", 32'(line_fwd[31:0]), 32'h0000_0008);
        wr(12'h000, 4'h1, 32'h0);
        check("R2 global off", 32'(line_fwd[31:0]), 0);
        wr(12'h000, 4'h1, 32'h1);
        wr(12'h180, 4'hF, 32'h0000_0008);
        check("R2 line disabled", 32'(line_fwd[31:0]), 0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule